// File: doc/BRIEF.md
# Hysteretic PLL Lock Detector

This block decides whether a phase-locked loop is locked by watching the phase detector inputs in the digital domain. It receives one-cycle pulses marking reference edges and feedback edges, already synchronized to a fast sampling clock. It measures the distance in sampling-clock ticks between each reference edge and its feedback partner, and sorts every phase-detector period into one of three classes: small error, medium error or large error.

The lock flag uses asymmetric hysteresis. To raise the flag, a long unbroken run of small-error periods is needed. Once the flag is high, only a large error lowers it. A new-channel pulse from the programming logic also clears it at once. Medium errors while locked leave the flag alone. The flag may rise briefly and falsely near a cycle slip, but any large error always clears it, so it can be trusted as a loss-of-lock indicator. The thresholds and the run length are parameters expressed in sampling-clock ticks and periods.

Top module: `phase_lock_monitor`

## Requirements
- R1: After reset, lock_o is 0.
- R2: The error of a period is the number of sampling-clock cycles from the first edge pulse to its partner on the other input. Either input may come first. Pulses on both inputs in the same cycle give an error of 0.
- R3: lock_o goes to 1 after GOOD_RUN consecutive periods whose error is below LOCK_TICKS. After GOOD_RUN-1 such periods it is still 0.
- R4: While unlocked, a period with error at or above LOCK_TICKS sets the run count back to 0, so a full new run of GOOD_RUN small-error periods is needed.
- R5: While locked, a single period with error above UNLOCK_TICKS clears lock_o.
- R6: While locked, periods with error from LOCK_TICKS up to and including UNLOCK_TICKS leave lock_o at 1.
- R7: A new_chan pulse clears lock_o and the run count on the clock edge that samples it. It takes priority over any result in that cycle.
- R8: An edge whose partner does not arrive within UNLOCK_TICKS cycles produces a large-error result. This clears the lock, or resets the run count when unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | One-cycle pulse per reference edge |
| fb_pulse | input | 1 | One-cycle pulse per feedback edge |
| new_chan | input | 1 | One-cycle pulse when a new channel is programmed |
| lock_o | output | 1 | Lock indication |

## Verification
The bench targets the threshold edges. An error of exactly LOCK_TICKS must break a run, an error of exactly UNLOCK_TICKS must keep the lock, and UNLOCK_TICKS+1 must drop it. An off-by-one comparison would flip one of these outcomes. Runs of GOOD_RUN-1 small errors placed after a medium error, after a new_chan pulse and after a lone unpartnered edge catch a counter that is not cleared: such a design would lock early. Feedback-first pairs and coincident pulses catch a timer that only starts on the reference input.

// File: rtl/plm_pkg.sv
package plm_pkg;
  typedef enum logic [1:0] {
    ERR_GOOD = 2'd0,
    ERR_MID  = 2'd1,
    ERR_BAD  = 2'd2
  } err_class_t;
endpackage

// File: rtl/plm_edge_timer.sv
module plm_edge_timer #(
  parameter int UNLOCK_TICKS = 30,
  localparam int CNT_W = $clog2(UNLOCK_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  output logic             res_valid,
  output logic [CNT_W-1:0] res_err,
  output logic             res_timeout
);
  logic             pend_q, pend_d;
  logic             src_ref_q, src_ref_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             valid_d, tout_d;
  logic [CNT_W-1:0] err_d;
  logic             partner;

  assign partner = src_ref_q ? fb_pulse : ref_pulse;

  always_comb begin
    pend_d    = pend_q;
    src_ref_d = src_ref_q;
    cnt_d     = cnt_q;
    valid_d   = 1'b0;
    tout_d    = 1'b0;
    err_d     = '0;
    if (!pend_q) begin
      if (ref_pulse && fb_pulse) begin
        valid_d = 1'b1;
      end else if (ref_pulse || fb_pulse) begin
        pend_d    = 1'b1;
        src_ref_d = ref_pulse;
        cnt_d     = CNT_W'(1);
      end
    end else begin
      if (partner) begin
        valid_d = 1'b1;
        err_d   = cnt_q;
        pend_d  = 1'b0;
      end else if (cnt_q == CNT_W'(UNLOCK_TICKS)) begin
        valid_d = 1'b1;
        tout_d  = 1'b1;
        pend_d  = 1'b0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      src_ref_q   <= 1'b0;
      cnt_q       <= '0;
      res_valid   <= 1'b0;
      res_err     <= '0;
      res_timeout <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      src_ref_q <= src_ref_d;
      cnt_q     <= cnt_d;
      res_valid <= valid_d;
      if (valid_d) begin
        res_err     <= err_d;
        res_timeout <= tout_d;
      end
    end
  end
endmodule

// File: rtl/plm_err_class.sv
module plm_err_class
  import plm_pkg::*;
#(
  parameter int LOCK_TICKS   = 15,
  parameter int UNLOCK_TICKS = 30,
  localparam int CNT_W = $clog2(UNLOCK_TICKS + 1)
) (
  input  logic [CNT_W-1:0] err,
  input  logic             timeout,
  output err_class_t       cls
);
  always_comb begin
    if (timeout || (err > CNT_W'(UNLOCK_TICKS)))
      cls = ERR_BAD;
    else if (err < CNT_W'(LOCK_TICKS))
      cls = ERR_GOOD;
    else
      cls = ERR_MID;
  end
endmodule

// File: rtl/plm_lock_ctrl.sv
module plm_lock_ctrl
  import plm_pkg::*;
#(
  parameter int GOOD_RUN = 40,
  localparam int RUN_W = $clog2(GOOD_RUN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid,
  input  err_class_t       res_class,
  input  logic             new_chan,
  output logic             lock_q,
  output logic [RUN_W-1:0] run_q
);
  logic             lock_d;
  logic [RUN_W-1:0] run_d;
  logic             upd;

  always_comb begin
    lock_d = lock_q;
    run_d  = run_q;
    if (new_chan) begin
      lock_d = 1'b0;
      run_d  = '0;
    end else if (res_valid) begin
      if (lock_q) begin
        if (res_class == ERR_BAD) lock_d = 1'b0;
        run_d = '0;
      end else if (res_class == ERR_GOOD) begin
        if (run_q == RUN_W'(GOOD_RUN - 1)) begin
          lock_d = 1'b1;
          run_d  = '0;
        end else begin
          run_d = run_q + RUN_W'(1);
        end
      end else begin
        run_d = '0;
      end
    end
  end

  assign upd = new_chan | res_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      run_q  <= '0;
    end else if (upd) begin
      lock_q <= lock_d;
      run_q  <= run_d;
    end
  end
endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
  import plm_pkg::*;
#(
  parameter int LOCK_TICKS   = 15,
  parameter int UNLOCK_TICKS = 30,
  parameter int GOOD_RUN     = 40,
  localparam int CNT_W = $clog2(UNLOCK_TICKS + 1),
  localparam int RUN_W = $clog2(GOOD_RUN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_pulse,
  input  logic fb_pulse,
  input  logic new_chan,
  output logic lock_o
);
  logic             res_valid;
  logic [CNT_W-1:0] res_err;
  logic             res_timeout;
  err_class_t       res_class;
  logic [RUN_W-1:0] run_cnt;

  plm_edge_timer #(.UNLOCK_TICKS(UNLOCK_TICKS)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_pulse  (ref_pulse),
    .fb_pulse   (fb_pulse),
    .res_valid  (res_valid),
    .res_err    (res_err),
    .res_timeout(res_timeout)
  );

  plm_err_class #(.LOCK_TICKS(LOCK_TICKS), .UNLOCK_TICKS(UNLOCK_TICKS)) u_class (
    .err    (res_err),
    .timeout(res_timeout),
    .cls    (res_class)
  );

  plm_lock_ctrl #(.GOOD_RUN(GOOD_RUN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_valid(res_valid),
    .res_class(res_class),
    .new_chan (new_chan),
    .lock_q   (lock_o),
    .run_q    (run_cnt)
  );
endmodule

// File: rtl/plm_checker.sv
module plm_checker
  import plm_pkg::*;
#(
  parameter int RUN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             new_chan,
  input logic             lock_o,
  input logic             res_valid,
  input err_class_t       res_class,
  input logic [RUN_W-1:0] run_cnt
);
  assert_clear_on_new_chan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    new_chan |=> (!lock_o && run_cnt == '0));

  assert_drop_on_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && res_valid && res_class == ERR_BAD) |=> !lock_o);

  assert_hold_on_mid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && res_valid && res_class != ERR_BAD && !new_chan) |=> lock_o);

  assert_rise_needs_good_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(res_valid && res_class == ERR_GOOD && !new_chan));

  assert_run_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && res_valid && res_class != ERR_GOOD && !new_chan) |=> (run_cnt == '0 && !lock_o));

  assert_quiet_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_valid && !new_chan) |=> $stable(lock_o));
endmodule

bind phase_lock_monitor plm_checker #(.RUN_W(RUN_W)) u_plm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .new_chan (new_chan),
  .lock_o   (lock_o),
  .res_valid(res_valid),
  .res_class(res_class),
  .run_cnt  (run_cnt)
);

// File: tb/phase_lock_monitor_bench.sv
module phase_lock_monitor_bench;
  localparam int LK  = 6;
  localparam int UL  = 12;
  localparam int RUN = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pulse = 1'b0;
  logic fb_pulse = 1'b0;
  logic new_chan = 1'b0;
  logic lock_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic  exp;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  phase_lock_monitor #(.LOCK_TICKS(LK), .UNLOCK_TICKS(UL), .GOOD_RUN(RUN)) u_phase_lock_monitor (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .new_chan(new_chan), .lock_o(lock_o)
  );

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      n_run++;
      if (lock_o !== it.exp) begin
        n_fail++;
        $display("FAIL %s: lock_o=%b expected=%b", it.tag, lock_o, it.exp);
      end
    end
  end

  task automatic expect_lock(input logic e, input string tag);
    exp_t it;
    @(posedge clk); #1;
    it.exp = e;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic settle();
    repeat (UL + 6) @(negedge clk);
  endtask

  // One detector period with error e; fb_first swaps the edge order
  task automatic pfd(input int e, input bit fb_first);
    @(negedge clk);
    if (e == 0) begin
      ref_pulse = 1'b1; fb_pulse = 1'b1;
      @(negedge clk);
      ref_pulse = 1'b0; fb_pulse = 1'b0;
    end else begin
      if (fb_first) fb_pulse = 1'b1; else ref_pulse = 1'b1;
      @(negedge clk);
      ref_pulse = 1'b0; fb_pulse = 1'b0;
      repeat (e - 1) @(negedge clk);
      if (fb_first) ref_pulse = 1'b1; else fb_pulse = 1'b1;
      @(negedge clk);
      ref_pulse = 1'b0; fb_pulse = 1'b0;
    end
    settle();
  endtask

  task automatic good_run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      pfd(i % LK, i[0]);
      expect_lock(1'b0, tag);
    end
  endtask

  task automatic pulse_new_chan();
    @(negedge clk);
    new_chan = 1'b1;
    @(negedge clk);
    new_chan = 1'b0;
  endtask

  task automatic lone_edge();
    @(negedge clk);
    ref_pulse = 1'b1;
    @(negedge clk);
    ref_pulse = 1'b0;
    repeat (UL + 6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_lock(1'b0, "R1 reset state");

    good_run(RUN - 1, "R2/R3 short run, both orders and coincident");
    pfd(LK - 1, 1'b1);
    expect_lock(1'b1, "R3 lock after full run");

    pfd(LK, 1'b1);
    expect_lock(1'b1, "R6 error at lock threshold keeps lock");
    pfd(UL, 1'b0);
    expect_lock(1'b1, "R6 error at unlock threshold keeps lock");
    pfd(UL + 1, 1'b0);
    expect_lock(1'b0, "R5 error above unlock threshold drops lock");

    good_run(5, "R4 prefix run");
    pfd(LK, 1'b0);
    expect_lock(1'b0, "R4 medium error while unlocked");
    good_run(RUN - 1, "R4 run restarted after medium error");
    pfd(1, 1'b0);
    expect_lock(1'b1, "R4 lock after restarted run");

    pulse_new_chan();
    expect_lock(1'b0, "R7 new_chan clears lock");
    good_run(5, "R7 prefix run");
    pulse_new_chan();
    good_run(RUN - 1, "R7 run count cleared by new_chan");
    pfd(0, 1'b0);
    expect_lock(1'b1, "R7 lock after fresh run");

    lone_edge();
    expect_lock(1'b0, "R8 unpartnered edge drops lock");
    good_run(5, "R8 prefix run");
    lone_edge();
    expect_lock(1'b0, "R8 unpartnered edge while unlocked");
    good_run(RUN - 1, "R8 run restarted after lone edge");
    pfd(2, 1'b1);
    expect_lock(1'b1, "R8 lock after restarted run");

    wait (q.size() == 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule